// File: doc/BRIEF.md
# Board Interrupt and Control Register Bank

This block sits on a board-level controller as a bank of 16-bit registers that a host reads and writes over a simple synchronous halfword port addressed by byte offset. Its main job is interrupt collection. It gathers 32 level-sensitive request lines, shows them to the host as two raw status halfwords, and filters them through two mask halfwords. It drives one active-low level request to the host for as long as any source that is not masked stays asserted. Software clears a request at the peripheral that raised it, not in this bank. By board convention, source 15 carries the Ethernet controller's request.

The bank also holds a few board control and identification registers. Two 16-bit device reset control words are readable and writable; bit 2 of the first one holds the Ethernet device in reset. A backlight control bit turns the panel backlight on. Read-only registers give a version word built from two strap parameters, a snapshot of three clock-mode pins, and four halfwords that mirror the board's bus switch banks. Every external level passes through a two-flop synchronizer before it is used.

A read request that the port samples at a clock edge returns its data on `bus_rdata_o` after that edge. A write takes effect at the edge that samples it.

Top module: `brc_regbank`

## Requirements
- R1: Offset 0x0020 reads sources 15:0 and offset 0x0022 reads sources 31:16, bit n of each halfword being source n of that half. The value read is the source level after a two-flop synchronizer, so a level change at the pins shows in a read issued two clock edges later.
- R2: The mask halfwords at offsets 0x0030 (sources 15:0) and 0x0032 (sources 31:16) can be read and written. Bit n of each mask lines up with bit n of the matching status halfword.
- R3: A mask bit of 1 blocks its source and a mask bit of 0 passes it. `irq_n_o` is registered and is 0 while at least one passed source is 1, and 1 otherwise. It follows a pin change after three clock edges and a mask write after two edges.
- R4: While `rst_n` is low at a clock edge, both masks load 0xFFFF, `irq_n_o` goes to 1, both reset control words load 0x0000, and `backlight_o` loads 0.
- R5: The status halfwords are read-only. A write to 0x0020 or 0x0022 does not change what they read back.
- R6: The device reset words at 0x10D0 and 0x10D2 store all 16 bits, read back, and drive `dev_rst0_o` and `dev_rst1_o`. `eth_rst_o` follows bit 2 of the word at 0x10D0. Cycles with no write to them leave them unchanged.
- R7: Offset 0x1100 reads {CPU_REV[7:0], BASE_REV[7:0]}, CPU in bits 15:8, and a write there has no effect.
- R8: Offset 0x10E0 reads the synchronized `clk_mode_i[2:0]` in bits 10:8, with every other bit 0.
- R9: Offsets 0x0070, 0x0072, 0x0074 and 0x0076 read `bus_sw_i` halfwords 0 to 3 (bits 15:0, 31:16, 47:32, 63:48), synchronized. A switch in the ON position drives 0 on its bit.
- R10: Bit 0 of offset 0x10B4 holds the backlight enable, which drives `backlight_o`. The other bits read as 0.
- R11: A read of any other offset, odd offsets included, returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 13 | Byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid after the edge that took the read |
| irq_src_i | input | 32 | Level interrupt sources, active high |
| bus_sw_i | input | 64 | Four bus switch banks, ON reads 0 |
| clk_mode_i | input | 3 | Clock mode pins |
| irq_n_o | output | 1 | Active-low level interrupt to the host |
| dev_rst0_o | output | 16 | Device reset control word 0 |
| dev_rst1_o | output | 16 | Device reset control word 1 |
| eth_rst_o | output | 1 | Ethernet device reset (word 0 bit 2) |
| backlight_o | output | 1 | Panel backlight enable |

## Verification
If a mask bit were wrong inside the bank, it would show up within two edges of the mask write. `irq_n_o` would either assert for a source that is blocked or stay high for one that is passed. Reading the mask back confirms the fault on the next cycle. A slip in the synchronizer or the status decode would show as a read of 0x0020 or 0x0022 that disagrees with the pins four cycles after they settle. A bad decode in the control registers would show at `dev_rst*_o` or `backlight_o` straight after the write that should, or should not, have touched them.

// File: rtl/brc_pkg.sv
// Shared constants for the board register bank: data width, offset width
// and the byte offsets the host decodes. Assumes halfword-aligned offsets.
package brc_pkg;
    localparam int HW     = 16;
    localparam int ADDR_W = 13;

    localparam logic [ADDR_W-1:0] OFF_STAT_LO = 13'h0020;
    localparam logic [ADDR_W-1:0] OFF_STAT_HI = 13'h0022;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO = 13'h0030;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI = 13'h0032;
    localparam logic [ADDR_W-1:0] OFF_SW0     = 13'h0070;
    localparam logic [ADDR_W-1:0] OFF_SW1     = 13'h0072;
    localparam logic [ADDR_W-1:0] OFF_SW2     = 13'h0074;
    localparam logic [ADDR_W-1:0] OFF_SW3     = 13'h0076;
    localparam logic [ADDR_W-1:0] OFF_BLIGHT  = 13'h10B4;
    localparam logic [ADDR_W-1:0] OFF_RST0    = 13'h10D0;
    localparam logic [ADDR_W-1:0] OFF_RST1    = 13'h10D2;
    localparam logic [ADDR_W-1:0] OFF_MODE    = 13'h10E0;
    localparam logic [ADDR_W-1:0] OFF_VER     = 13'h1100;

    localparam int MODE_LSB = 8;
    localparam int ETH_RST_BIT = 2;
endpackage

// File: rtl/brc_sync.sv
// Multi-flop synchronizer for a vector of slow external levels.
// Assumes every bit changes slowly enough that bits need no coherence
// between them. Output is zero during reset.
module brc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // Purpose: shift the input level along the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/brc_irq_agg.sv
// Interrupt mask bank and aggregation. Holds one mask halfword for each
// group of 16 sources (1 = blocked) and drives a registered active-low
// request. Assumes the status input is already synchronized.
module brc_irq_agg #(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        status_i,
    input  logic [NUM_SRC/16-1:0]     mask_we_i,
    input  logic [15:0]               wdata_i,
    output logic [NUM_SRC-1:0]        mask_o,
    output logic                      irq_n_o
);
    localparam int NHALF = NUM_SRC / 16;

    logic [NUM_SRC-1:0] mask_q;
    logic               irq_n_q;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        // Purpose: load one mask halfword on its write strobe; all-blocked at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)            mask_q[h*16 +: 16] <= 16'hFFFF;
            else if (mask_we_i[h]) mask_q[h*16 +: 16] <= wdata_i;
        end
    end

    // Purpose: register the OR of all passed sources as an active-low request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~(|(status_i & ~mask_q));
    end

    assign mask_o  = mask_q;
    assign irq_n_o = irq_n_q;

    AST_MASK_RESET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask_q && irq_n_q)); // R4
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(mask_q)) |-> irq_n_q); // R3
    AST_SRC0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_i[0]) && !$past(mask_q[0])) |-> !irq_n_q); // R3
endmodule

// File: rtl/brc_ctl_regs.sv
// Board control registers: two device reset words and the backlight bit.
// Assumes write strobes are one-hot and come from the top-level decode.
module brc_ctl_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_rst0_i,
    input  logic        we_rst1_i,
    input  logic        we_bl_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rst0_o,
    output logic [15:0] rst1_o,
    output logic        bl_o
);
    logic [15:0] rst0_q;
    logic [15:0] rst1_q;
    logic        bl_q;

    // Purpose: capture host writes into the control registers; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst0_q <= '0;
            rst1_q <= '0;
            bl_q   <= 1'b0;
        end else begin
            if (we_rst0_i) rst0_q <= wdata_i;
            if (we_rst1_i) rst1_q <= wdata_i;
            if (we_bl_i)   bl_q   <= wdata_i[0];
        end
    end

    assign rst0_o = rst0_q;
    assign rst1_o = rst1_q;
    assign bl_o   = bl_q;

    AST_CTL_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_rst0_i || we_rst1_i || we_bl_i) |=> $stable({rst0_q, rst1_q, bl_q})); // R6
endmodule

// File: rtl/brc_regbank.sv
// Top of the board register bank. It decodes the halfword host port,
// synchronizes external levels, instantiates the interrupt aggregator and
// the control registers, and registers read data.
// Assumes one access per cycle and that the version straps are constant.
module brc_regbank
    import brc_pkg::*;
#(
    parameter int          NUM_SRC  = 32,
    parameter int          SYNC_STG = 2,
    parameter logic [7:0]  CPU_REV  = 8'h12,
    parameter logic [7:0]  BASE_REV = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [12:0]       bus_addr_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    input  logic [31:0]       irq_src_i,
    input  logic [63:0]       bus_sw_i,
    input  logic [2:0]        clk_mode_i,
    output logic              irq_n_o,
    output logic [15:0]       dev_rst0_o,
    output logic [15:0]       dev_rst1_o,
    output logic              eth_rst_o,
    output logic              backlight_o
);
    localparam int NHALF = NUM_SRC / 16;
    localparam int SW_W  = 64;

    logic [NUM_SRC-1:0] src_sync;
    logic [SW_W-1:0]    sw_sync;
    logic [2:0]         mode_sync;
    logic [NUM_SRC-1:0] mask_w;
    logic [NHALF-1:0]   mask_we;
    logic               wr_en, rd_en;
    logic               hit;
    logic [HW-1:0]      rd_mux;
    logic [HW-1:0]      rdata_q;

    brc_sync #(.W(NUM_SRC), .STAGES(SYNC_STG)) u_sync_src (
        .clk(clk), .rst_n(rst_n), .d_i(irq_src_i), .q_o(src_sync));
    brc_sync #(.W(SW_W), .STAGES(SYNC_STG)) u_sync_sw (
        .clk(clk), .rst_n(rst_n), .d_i(bus_sw_i), .q_o(sw_sync));
    brc_sync #(.W(3), .STAGES(SYNC_STG)) u_sync_mode (
        .clk(clk), .rst_n(rst_n), .d_i(clk_mode_i), .q_o(mode_sync));

    assign wr_en = bus_sel_i &  bus_wr_i;
    assign rd_en = bus_sel_i & ~bus_wr_i;

    assign mask_we[0] = wr_en && (bus_addr_i == OFF_MASK_LO);
    assign mask_we[1] = wr_en && (bus_addr_i == OFF_MASK_HI);

    brc_irq_agg #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .status_i(src_sync), .mask_we_i(mask_we),
        .wdata_i(bus_wdata_i), .mask_o(mask_w), .irq_n_o(irq_n_o));

    brc_ctl_regs u_ctl (
        .clk(clk), .rst_n(rst_n),
        .we_rst0_i(wr_en && (bus_addr_i == OFF_RST0)),
        .we_rst1_i(wr_en && (bus_addr_i == OFF_RST1)),
        .we_bl_i  (wr_en && (bus_addr_i == OFF_BLIGHT)),
        .wdata_i(bus_wdata_i),
        .rst0_o(dev_rst0_o), .rst1_o(dev_rst1_o), .bl_o(backlight_o));

    assign eth_rst_o = dev_rst0_o[ETH_RST_BIT];

    // Purpose: select the read value for the addressed offset; flag unmapped ones.
    always_comb begin
        rd_mux = '0;
        hit    = 1'b1;
        unique case (bus_addr_i)
            OFF_STAT_LO: rd_mux = src_sync[15:0];
            OFF_STAT_HI: rd_mux = src_sync[31:16];
            OFF_MASK_LO: rd_mux = mask_w[15:0];
            OFF_MASK_HI: rd_mux = mask_w[31:16];
            OFF_SW0:     rd_mux = sw_sync[15:0];
            OFF_SW1:     rd_mux = sw_sync[31:16];
            OFF_SW2:     rd_mux = sw_sync[47:32];
            OFF_SW3:     rd_mux = sw_sync[63:48];
            OFF_BLIGHT:  rd_mux = {15'd0, backlight_o};
            OFF_RST0:    rd_mux = dev_rst0_o;
            OFF_RST1:    rd_mux = dev_rst1_o;
            OFF_MODE:    rd_mux = {5'd0, mode_sync, 8'd0};
            OFF_VER:     rd_mux = {CPU_REV, BASE_REV};
            default:     hit    = 1'b0;
        endcase
    end

    // Purpose: register read data on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (bus_rdata_o == 16'h0000)); // R11
    AST_ETH_FOLLOWS_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr_i == OFF_RST0) |=> (eth_rst_o == $past(bus_wdata_i[ETH_RST_BIT]))); // R6
endmodule

// File: tb/brc_regbank_tb.sv
// Scoreboard bench: a driver task queues the expected read data, and a
// monitor compares each returned halfword on the cycle after the read.
module brc_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0;
    logic [12:0] bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [31:0] irq_src_i = '0;
    logic [63:0] bus_sw_i = '0;
    logic [2:0]  clk_mode_i = '0;
    logic        irq_n_o, eth_rst_o, backlight_o;
    logic [15:0] dev_rst0_o, dev_rst1_o;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    brc_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .irq_src_i(irq_src_i), .bus_sw_i(bus_sw_i), .clk_mode_i(clk_mode_i),
        .irq_n_o(irq_n_o), .dev_rst0_o(dev_rst0_o), .dev_rst1_o(dev_rst1_o),
        .eth_rst_o(eth_rst_o), .backlight_o(backlight_o));

    // Mark the cycles on which the design accepted a read.
    always @(posedge clk) rd_seen <= bus_sel_i & ~bus_wr_i;

    // Monitor: pop one expected item per accepted read and compare.
    always @(negedge clk) begin
        if (rd_seen) begin
            string t;
            logic [15:0] e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            n_cmp++;
            if (bus_rdata_o !== e) begin
                n_bad++;
                $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata_o, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [12:0] a, input logic [15:0] exp);
        @(negedge clk);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_sel_i = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        settle(3);
        // R4: reset values
        chk("R4 irq_n", {15'd0, irq_n_o}, 16'h0001);
        chk("R4 rst0", dev_rst0_o, 16'h0000);
        chk("R4 rst1", dev_rst1_o, 16'h0000);
        chk("R4 backlight", {15'd0, backlight_o}, 16'h0000);
        rst_n = 1'b1;
        settle(1);
        rd("R4 mask_lo", 13'h0030, 16'hFFFF);
        rd("R4 mask_hi", 13'h0032, 16'hFFFF);

        // R1: status halves, all masked so no request (R3)
        irq_src_i = 32'h8001_8000;
        settle(4);
        rd("R1 stat_lo", 13'h0020, 16'h8000);
        rd("R1 stat_hi", 13'h0022, 16'h8001);
        chk("R3 masked quiet", {15'd0, irq_n_o}, 16'h0001);

        // R2/R3: unmask source 15
        wr(13'h0030, 16'h7FFF);
        settle(1);
        chk("R3 src15 passes", {15'd0, irq_n_o}, 16'h0000);
        rd("R2 mask_lo rb", 13'h0030, 16'h7FFF);
        wr(13'h0030, 16'hFFFF);
        settle(1);
        chk("R3 remask", {15'd0, irq_n_o}, 16'h0001);
        wr(13'h0032, 16'hFFFE);
        settle(1);
        chk("R3 src16 passes", {15'd0, irq_n_o}, 16'h0000);
        rd("R2 mask_hi rb", 13'h0032, 16'hFFFE);
        wr(13'h0032, 16'h7FFF);
        settle(1);
        chk("R3 src31 passes", {15'd0, irq_n_o}, 16'h0000);
        wr(13'h0032, 16'hFFFF);
        settle(1);
        chk("R3 hi remask", {15'd0, irq_n_o}, 16'h0001);

        // R3: level follows the source with all low sources passed
        wr(13'h0030, 16'h0000);
        irq_src_i = 32'h0000_0000;
        settle(4);
        chk("R3 source cleared", {15'd0, irq_n_o}, 16'h0001);
        irq_src_i = 32'h0000_0008;
        settle(4);
        chk("R3 source 3 set", {15'd0, irq_n_o}, 16'h0000);

        // R5: status ignores writes
        wr(13'h0020, 16'hFFFF);
        rd("R5 stat_lo after write", 13'h0020, 16'h0008);
        irq_src_i = 32'h0;
        settle(4);
        rd("R1 stat_lo cleared", 13'h0020, 16'h0000);

        // R6: device reset words
        wr(13'h10D0, 16'h0004);
        chk("R6 eth reset", {15'd0, eth_rst_o}, 16'h0001);
        chk("R6 rst0 out", dev_rst0_o, 16'h0004);
        wr(13'h10D2, 16'hA5A5);
        chk("R6 rst1 out", dev_rst1_o, 16'hA5A5);
        rd("R6 rst1 rb", 13'h10D2, 16'hA5A5);
        wr(13'h10D0, 16'h0000);
        chk("R6 eth release", {15'd0, eth_rst_o}, 16'h0000);

        // R7: version, read-only
        wr(13'h1100, 16'h0000);
        rd("R7 version", 13'h1100, 16'h1234);

        // R8: mode pins
        clk_mode_i = 3'b101;
        settle(4);
        rd("R8 mode", 13'h10E0, 16'h0500);

        // R9: bus switch banks
        bus_sw_i = 64'hDEAD_BEEF_0F0F_F0F0;
        settle(4);
        rd("R9 sw0", 13'h0070, 16'hF0F0);
        rd("R9 sw1", 13'h0072, 16'h0F0F);
        rd("R9 sw2", 13'h0074, 16'hBEEF);
        rd("R9 sw3", 13'h0076, 16'hDEAD);

        // R10: backlight bit only
        wr(13'h10B4, 16'hFFFF);
        chk("R10 backlight on", {15'd0, backlight_o}, 16'h0001);
        rd("R10 blight rb", 13'h10B4, 16'h0001);
        wr(13'h10B4, 16'hFFFE);
        chk("R10 backlight off", {15'd0, backlight_o}, 16'h0000);

        // R11: unmapped offsets
        rd("R11 gap", 13'h0040, 16'h0000);
        rd("R11 odd", 13'h0021, 16'h0000);
        settle(2);
        done = 1'b1;
    end

    // Watchdog and end of run.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule